// File: doc/BRIEF.md
# Page Write Collector and Programming Timer

This block sits behind the serial command decoder of a byte-addressed non-volatile memory. When a write command begins, it latches the target address. It then gathers the data bytes that follow into a one-page staging buffer. The buffer is indexed by the low address bits, and those bits step by one per byte and wrap inside the page. The upper address bits never change during a command. If more bytes arrive than the page holds, the newest byte at each position replaces the older one.

The decoder reports when chip select goes high. It also reports whether that edge came exactly on a byte boundary, and whether writing is currently allowed (write-enable latch set and target not protected). On a valid commit, the block enters a self-timed programming cycle. It first emits one array write strobe for each staged position that actually received a byte, in ascending in-page order. It then holds busy until a parameterised number of timer ticks has elapsed since the commit. The tick input sets the time base, so a short tick count can stand in for the real program time in simulation. When the cycle ends, the block pulses a request to clear the write-enable latch. Any other end of the command throws the staged data away.

Top module: `pwb_page_writer`

## Requirements
- R1: After reset, `busy_o`, `arr_we_o` and `wel_clr_o` are all low, and no programming cycle runs until a commit.
- R2: The first data byte after `cmd_start_i` goes to in-page offset `cmd_addr_i[4:0]`. Each later byte goes to the next offset modulo 32. Every array write of a cycle carries the upper bits `cmd_addr_i[12:5]` of that command.
- R3: When more than 32 bytes are sent, the offset wraps, and the byte written to a position is the last one received for it.
- R4: A commit happens only when `cs_rise_i` arrives with `cs_aligned_i`=1 and at least one byte collected. A rise with `cs_aligned_i`=0, or with no byte collected, discards the data with no busy and no array write.
- R5: A rise with `wr_allow_i`=0 drops the command: no busy, no array write and no latch clear.
- R6: During a cycle, exactly the offsets that received a byte are written, each once, in ascending offset order. Positions that were not touched get no strobe.
- R7: `busy_o` rises in the cycle after a valid commit. It stays high until exactly `PROG_TICKS` ticks (cycles with `tick_i`=1 while busy) have been counted and the write sweep is complete. All array writes occur while `busy_o` is high.
- R8: `wel_clr_o` pulses for exactly one cycle, in the cycle `busy_o` falls, once per programming cycle.
- R9: While busy, `cmd_start_i`, `byte_vld_i` and `cs_rise_i` are ignored. They produce no extra array write, no second cycle, and no change to the running cycle's length.
- R10: A new `cmd_start_i` before chip select rises discards the bytes collected so far and restarts collection at the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_start_i | input | 1 | Write command decoded; latch start address |
| cmd_addr_i | input | ADDR_W | Start address of the write command |
| byte_vld_i | input | 1 | One complete data byte received |
| byte_data_i | input | DATA_W | Received data byte |
| cs_rise_i | input | 1 | Chip select went high |
| cs_aligned_i | input | 1 | The rise fell exactly on a byte boundary |
| wr_allow_i | input | 1 | Write enabled and target not protected |
| tick_i | input | 1 | Programming time base tick |
| busy_o | output | 1 | Programming cycle in progress |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_data_o | output | DATA_W | Array write data |
| wel_clr_o | output | 1 | Clear request for the write-enable latch |

## Verification
Short writes starting mid-page show whether the offset steps from the given start. Writes that start near the page end show whether the offset wraps while the upper bits stay fixed. Overlong bursts show whether later bytes replace earlier ones. Misaligned rises, empty commands and disallowed commands each isolate one condition of the commit rule. A restart in the middle of collection, and traffic injected while busy, separate a missing clear from a missing lockout. Random addresses, lengths and qualifiers mix all of these, and every transaction is compared for exact strobe order, tick-accurate busy length and a single latch clear.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_PROG    = 2'd2
    } pwb_state_e;
endpackage

// File: rtl/pwb_page_store.sv
module pwb_page_store #(
    parameter int PAGE_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              wr_i,
    input  logic [PAGE_W-1:0] wr_off_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [PAGE_W-1:0] rd_off_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_vld_o,
    output logic              any_vld_o
);
    localparam int DEPTH = 1 << PAGE_W;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] data;
        logic [DEPTH-1:0]             vld;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.vld = '0;
        end
        if (wr_i) begin
            st_d.data[wr_off_i] = wr_data_i;
            st_d.vld[wr_off_i]  = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = st_q.data[rd_off_i];
    assign rd_vld_o  = st_q.vld[rd_off_i];
    assign any_vld_o = |st_q.vld;
endmodule

// File: rtl/pwb_prog_timer.sv
module pwb_prog_timer #(
    parameter int TICKS = 5000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic run_i,
    input  logic tick_i,
    output logic expired_o
);
    localparam int CNT_W = $clog2(TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(TICKS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICKS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = '0;
        end else if (run_i && tick_i && (cnt_q != CNT_END)) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == CNT_END) ||
                       (run_i && tick_i && (cnt_q == CNT_LAST));
endmodule

// File: rtl/pwb_drain_seq.sv
module pwb_drain_seq #(
    parameter int PAGE_W = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    output logic [PAGE_W-1:0] idx_o,
    output logic              done_o
);
    localparam int IDX_W = PAGE_W + 1;
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(1 << PAGE_W);

    logic [IDX_W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (start_i) begin
            idx_d = '0;
        end else if (idx_q != IDX_END) begin
            idx_d = idx_q + IDX_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            idx_q <= IDX_END;
        end else begin
            idx_q <= idx_d;
        end
    end

    assign idx_o  = idx_q[PAGE_W-1:0];
    assign done_o = (idx_q == IDX_END);
endmodule

// File: rtl/pwb_page_writer.sv
module pwb_page_writer
    import pwb_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int DATA_W     = 8,
    parameter int PAGE_W     = 5,
    parameter int PROG_TICKS = 5000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cmd_start_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic              byte_vld_i,
    input  logic [DATA_W-1:0] byte_data_i,
    input  logic              cs_rise_i,
    input  logic              cs_aligned_i,
    input  logic              wr_allow_i,
    input  logic              tick_i,
    output logic              busy_o,
    output logic              arr_we_o,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic [DATA_W-1:0] arr_data_o,
    output logic              wel_clr_o
);
    localparam int HI_W = ADDR_W - PAGE_W;

    typedef struct packed {
        pwb_state_e        st;
        logic [HI_W-1:0]   base;
        logic [PAGE_W-1:0] ptr;
        logic              wel_clr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              buf_clr;
    logic              buf_wr;
    logic              commit;
    logic              any_vld;
    logic              slot_vld;
    logic [DATA_W-1:0] slot_data;
    logic [PAGE_W-1:0] sweep_idx;
    logic              sweep_done;
    logic              time_up;

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.wel_clr = 1'b0;
        buf_clr       = 1'b0;
        buf_wr        = 1'b0;
        commit        = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (cmd_start_i) begin
                    ctl_d.st   = ST_COLLECT;
                    ctl_d.base = cmd_addr_i[ADDR_W-1:PAGE_W];
                    ctl_d.ptr  = cmd_addr_i[PAGE_W-1:0];
                    buf_clr    = 1'b1;
                end
            end
            ST_COLLECT: begin
                if (cmd_start_i) begin
                    ctl_d.base = cmd_addr_i[ADDR_W-1:PAGE_W];
                    ctl_d.ptr  = cmd_addr_i[PAGE_W-1:0];
                    buf_clr    = 1'b1;
                end else begin
                    if (byte_vld_i) begin
                        buf_wr    = 1'b1;
                        ctl_d.ptr = ctl_q.ptr + PAGE_W'(1);
                    end
                    if (cs_rise_i) begin
                        if (cs_aligned_i && wr_allow_i && (any_vld || byte_vld_i)) begin
                            commit   = 1'b1;
                            ctl_d.st = ST_PROG;
                        end else begin
                            ctl_d.st = ST_IDLE;
                        end
                    end
                end
            end
            ST_PROG: begin
                if (sweep_done && time_up) begin
                    ctl_d.st      = ST_IDLE;
                    ctl_d.wel_clr = 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '{st: ST_IDLE, base: '0, ptr: '0, wel_clr: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    pwb_page_store #(
        .PAGE_W (PAGE_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (buf_clr),
        .wr_i      (buf_wr),
        .wr_off_i  (ctl_q.ptr),
        .wr_data_i (byte_data_i),
        .rd_off_i  (sweep_idx),
        .rd_data_o (slot_data),
        .rd_vld_o  (slot_vld),
        .any_vld_o (any_vld)
    );

    pwb_drain_seq #(
        .PAGE_W (PAGE_W)
    ) u_sweep (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (commit),
        .idx_o   (sweep_idx),
        .done_o  (sweep_done)
    );

    pwb_prog_timer #(
        .TICKS (PROG_TICKS)
    ) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (commit),
        .run_i     (ctl_q.st == ST_PROG),
        .tick_i    (tick_i),
        .expired_o (time_up)
    );

    assign busy_o     = (ctl_q.st == ST_PROG);
    assign arr_we_o   = busy_o && !sweep_done && slot_vld;
    assign arr_addr_o = {ctl_q.base, sweep_idx};
    assign arr_data_o = slot_data;
    assign wel_clr_o  = ctl_q.wel_clr;
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              cs_rise_i,
    input logic              cs_aligned_i,
    input logic              wr_allow_i,
    input logic              busy_o,
    input logic              arr_we_o,
    input logic [ADDR_W-1:0] arr_addr_o,
    input logic              wel_clr_o
);
    a_r7_we_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arr_we_o |-> busy_o);

    a_r7_busy_needs_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(cs_rise_i && cs_aligned_i && wr_allow_i));

    a_r5_no_allow_no_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !wr_allow_i) |=> !busy_o);

    a_r8_clear_at_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> wel_clr_o);

    a_r8_clear_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wel_clr_o |-> (!busy_o && $past(busy_o)));

    a_r2_upper_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arr_we_o && $past(arr_we_o)) |->
            (arr_addr_o[ADDR_W-1:PAGE_W] == $past(arr_addr_o[ADDR_W-1:PAGE_W])));

    a_r6_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arr_we_o && $past(arr_we_o)) |->
            (arr_addr_o[PAGE_W-1:0] > $past(arr_addr_o[PAGE_W-1:0])));
endmodule

bind pwb_page_writer pwb_checker #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_rise_i    (cs_rise_i),
    .cs_aligned_i (cs_aligned_i),
    .wr_allow_i   (wr_allow_i),
    .busy_o       (busy_o),
    .arr_we_o     (arr_we_o),
    .arr_addr_o   (arr_addr_o),
    .wel_clr_o    (wel_clr_o)
);

// File: tb/tb_pwb_page_writer.sv
`timescale 1ns/1ps
module tb_pwb_page_writer;
    localparam int AW   = 13;
    localparam int PT   = 20;
    localparam int TDIV = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_start = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic          byte_vld = 1'b0;
    logic [7:0]    byte_data = '0;
    logic          cs_rise = 1'b0;
    logic          cs_aligned = 1'b0;
    logic          wr_allow = 1'b0;
    logic          tick = 1'b0;
    logic          busy, arr_we, wel_clr;
    logic [AW-1:0] arr_addr;
    logic [7:0]    arr_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    pwb_page_writer #(.ADDR_W(AW), .DATA_W(8), .PAGE_W(5), .PROG_TICKS(PT)) dut (
        .clk_i(clk), .rst_ni(rst_n), .cmd_start_i(cmd_start), .cmd_addr_i(cmd_addr),
        .byte_vld_i(byte_vld), .byte_data_i(byte_data), .cs_rise_i(cs_rise),
        .cs_aligned_i(cs_aligned), .wr_allow_i(wr_allow), .tick_i(tick),
        .busy_o(busy), .arr_we_o(arr_we), .arr_addr_o(arr_addr),
        .arr_data_o(arr_data), .wel_clr_o(wel_clr)
    );

    always #2.5 clk = ~clk;

    initial begin
        int tc;
        tc = 0;
        forever begin
            @(posedge clk);
            tc = (tc + 1) % TDIV;
            tick <= (tc == 0);
        end
    end

    // observed traffic
    logic [AW-1:0] got_a[$];
    logic [7:0]    got_d[$];
    int tick_cnt, wel_cnt, busy_rises;
    bit busy_prev = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (arr_we) begin
                got_a.push_back(arr_addr);
                got_d.push_back(arr_data);
            end
            if (busy && tick) tick_cnt++;
            if (wel_clr) wel_cnt++;
            if (busy && !busy_prev) busy_rises++;
            busy_prev = busy;
        end
    end

    // bench model of the page
    logic [7:0]      m_data[32];
    bit              m_vld[32];
    logic [AW-6:0]   m_base;
    logic [4:0]      m_ptr;
    bit              mdl_on = 1'b1;

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit any_model();
        for (int i = 0; i < 32; i++) if (m_vld[i]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic clear_obs();
        got_a.delete();
        got_d.delete();
        tick_cnt = 0;
        wel_cnt = 0;
        busy_rises = 0;
    endtask

    task automatic send_start(input logic [AW-1:0] a);
        @(negedge clk);
        cmd_start = 1'b1;
        cmd_addr  = a;
        if (mdl_on) begin
            m_base = a[AW-1:5];
            m_ptr  = a[4:0];
            for (int i = 0; i < 32; i++) m_vld[i] = 1'b0;
        end
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d);
        @(negedge clk);
        byte_vld  = 1'b1;
        byte_data = d;
        if (mdl_on) begin
            m_data[m_ptr] = d;
            m_vld[m_ptr]  = 1'b1;
            m_ptr         = m_ptr + 5'd1;
        end
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic send_rise(input bit al, input bit ok);
        @(negedge clk);
        cs_rise    = 1'b1;
        cs_aligned = al;
        wr_allow   = ok;
        @(negedge clk);
        cs_rise    = 1'b0;
        cs_aligned = 1'b0;
        wr_allow   = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 2000 && busy; k++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // compare observed traffic with the model after one commit
    task automatic compare_commit(input string tag);
        int n;
        n = 0;
        for (int i = 0; i < 32; i++) begin
            if (m_vld[i]) begin
                if (n < got_a.size()) begin
                    check({tag, " R2 addr"}, int'(got_a[n]), int'({m_base, 5'(i)}));
                    check({tag, " R3 data"}, int'(got_d[n]), int'(m_data[i]));
                end
                n++;
            end
        end
        check({tag, " R6 write count"}, got_a.size(), n);
        check({tag, " R7 ticks while busy"}, tick_cnt, PT);
        check({tag, " R8 latch clears"}, wel_cnt, 1);
        check({tag, " R9 single cycle"}, busy_rises, 1);
    endtask

    task automatic txn(input string tag, input logic [AW-1:0] a, input int nb,
                       input bit al, input bit ok);
        bit expect_commit;
        clear_obs();
        send_start(a);
        for (int i = 0; i < nb; i++) send_byte(8'($urandom));
        expect_commit = al && ok && any_model();
        send_rise(al, ok);
        if (expect_commit) begin
            check({tag, " R7 busy after commit"}, int'(busy), 1);
            wait_idle();
            compare_commit(tag);
        end else begin
            repeat (PT * TDIV + 40) @(negedge clk);
            check({tag, " R4 R5 no writes"}, got_a.size(), 0);
            check({tag, " R4 R5 no busy"}, busy_rises, 0);
            check({tag, " R5 no latch clear"}, wel_cnt, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check("R1 we", int'(arr_we), 0);
        check("R1 wel_clr", int'(wel_clr), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle after release", int'(busy), 0);

        txn("short R2", 13'h0105, 3, 1'b1, 1'b1);
        txn("wrap R3", 13'h0ABE, 4, 1'b1, 1'b1);
        txn("overflow R3", 13'h1442, 40, 1'b1, 1'b1);
        txn("full page R6", 13'h0200, 32, 1'b1, 1'b1);
        txn("misaligned R4", 13'h0010, 5, 1'b0, 1'b1);
        txn("empty R4", 13'h0333, 0, 1'b1, 1'b1);
        txn("disallowed R5", 13'h0444, 6, 1'b1, 1'b0);

        // R10 restart discards earlier bytes
        clear_obs();
        send_start(13'h0701);
        send_byte(8'hAA);
        send_byte(8'hBB);
        send_start(13'h0C1F);
        send_byte(8'h5C);
        send_rise(1'b1, 1'b1);
        wait_idle();
        compare_commit("restart R10");

        // R9 traffic while busy is ignored
        clear_obs();
        send_start(13'h0066);
        send_byte(8'h11);
        send_byte(8'h22);
        send_rise(1'b1, 1'b1);
        mdl_on = 1'b0;
        send_start(13'h1F00);
        send_byte(8'hEE);
        send_rise(1'b1, 1'b1);
        mdl_on = 1'b1;
        wait_idle();
        repeat (PT * TDIV) @(negedge clk);
        compare_commit("busy lockout R9");

        // random mix
        for (int t = 0; t < 30; t++) begin
            txn("random", AW'($urandom), $urandom_range(0, 45),
                ($urandom % 4) != 0, ($urandom % 4) != 0);
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule